// File: doc/BRIEF.md
# Thermal Input Assertion Timer

The block measures how long an active-low thermal override input is held low and reports that time to software. The input is first synchronized to the local clock. A prescaler supplies a one-clock tick pulse as the time unit, nominally 22.76 ms, so an 8-bit count spans about 5.82 s. The count keeps adding across separate assertions and stops at its maximum. It clears when software reads the status byte.

The low bit of the status byte has two jobs. Until two time units have built up, the upper bits read zero and bit 0 shows only that the input has asserted since the last read. From two units on, the byte is the full elapsed count. A programmable limit sets a sticky interrupt when the count exceeds it. A limit of zero raises the interrupt as soon as the input asserts. While the function is enabled and boost is configured, a boost output tells the fan logic to force maximum duty for as long as the input is asserted. A lock bit freezes the configuration byte.

The register port has a 2-bit address. A read returns data combinationally from `addr_i`. A read strobe clears state on the clock edge at the end of that cycle.

Top module: `therm_timer`

## Requirements
- R1: After reset every register reads 0x00, and `irq_o` and `boost_o` are 0.
- R2: The thermal input acts two clocks after it changes, through a two-stage synchronizer. The count advances by one only on clocks where `tick_i` is high and the synchronized input is low with the function enabled. The count keeps adding across separate assertions until it is cleared.
- R3: The status byte is at address 2. While the count is below 2 it reads {7'b0, flag}. The flag is set on every clock where the synchronized input is asserted with the function enabled. Once the count is 2 or more, the status byte reads the count.
- R4: A read strobe at address 2 clears both the count and the flag on that edge. The clear takes priority over a tick or a flag set in the same cycle.
- R5: The count saturates at 0xFF and holds there until it is cleared.
- R6: The interrupt-pending bit is bit 0 of address 3. It is set on a clock where the input is asserted and the count exceeds the limit at address 1. It stays set until a read strobe at address 3, and that clear takes priority over a set.
- R7: With the limit at 0x00, the pending bit sets on the first clock the synchronized input is asserted, before any tick.
- R8: `irq_o` is the pending bit ANDed with the interrupt mask. The mask is written and read as bit 1 of address 3.
- R9: `boost_o` is high while the synchronized input is asserted, enable (bit 0 of address 0) is 1 and boost (bit 1 of address 0) is 1.
- R10: With enable at 0, the input has no effect on the count, the flag, the pending bit or `boost_o`.
- R11: Bit 7 of address 0 is the lock bit. Once a write sets it, later writes to address 0 are ignored until reset. Address 0 reads back {lock, 5'b0, boost, enable}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock time-unit pulse from the prescaler |
| therm_ni | input | 1 | Thermal override input, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears on read) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Masked interrupt |
| boost_o | output | 1 | Force maximum fan duty |

## Verification
Internal state is fully visible at the ports. A wrong count, flag or synchronizer delay changes the status byte on the very next compared cycle, because the status is read combinationally every cycle. A pending bit that sets late, early or never shows on `irq_o` and address 3 within one clock of the cycle that should have set it. A lock or enable fault shows up as a different address 0 readback or `boost_o` value on the cycle after the write or the input change.

// File: rtl/therm_pkg.sv
`timescale 1ns/1ps
package therm_pkg;
  typedef enum logic [1:0] {
    ADDR_CFG    = 2'd0,
    ADDR_LIMIT  = 2'd1,
    ADDR_STATUS = 2'd2,
    ADDR_IRQ    = 2'd3
  } addr_e;

  typedef struct packed {
    logic lock;
    logic boost;
    logic en;
  } cfg_t;

  localparam int unsigned CFG_EN_BIT    = 0;
  localparam int unsigned CFG_BOOST_BIT = 1;
  localparam int unsigned CFG_LOCK_BIT  = 7;
  localparam int unsigned IRQ_MASK_BIT  = 1;
endpackage

// File: rtl/therm_sync.sv
`timescale 1ns/1ps
module therm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic sync_no
);
  logic [STAGES-1:0] q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q[i] <= 1'b1;
          else         q[i] <= async_ni;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q[i] <= 1'b1;
          else         q[i] <= q[i-1];
      end
    end
  endgenerate

  assign sync_no = q[STAGES-1];
endmodule

// File: rtl/therm_regs.sv
`timescale 1ns/1ps
module therm_regs
  import therm_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output cfg_t          cfg_o,
  output logic [DW-1:0] limit_o,
  output logic          mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o   <= '0;
      limit_o <= '0;
      mask_o  <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        ADDR_CFG: if (!cfg_o.lock) begin
          cfg_o.lock  <= wdata_i[CFG_LOCK_BIT];
          cfg_o.boost <= wdata_i[CFG_BOOST_BIT];
          cfg_o.en    <= wdata_i[CFG_EN_BIT];
        end
        ADDR_LIMIT: limit_o <= wdata_i;
        ADDR_IRQ:   mask_o  <= wdata_i[IRQ_MASK_BIT];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/therm_count.sv
`timescale 1ns/1ps
module therm_count #(
  parameter int unsigned CW         = 8,
  parameter int unsigned FLAG_UNITS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] status_o
);
  localparam logic [CW-1:0] FLAG_LVL = CW'(FLAG_UNITS);
  localparam logic [CW-1:0] CNT_MAX  = '1;

  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      flag_q <= 1'b0;
    end else if (clr_i) begin
      cnt_o  <= '0;
      flag_q <= 1'b0;
    end else if (run_i) begin
      flag_q <= 1'b1;
      if (tick_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end

  // low bit is a flag until the count reaches FLAG_UNITS
  assign status_o = (cnt_o >= FLAG_LVL) ? cnt_o : {{(CW-1){1'b0}}, flag_q};
endmodule

// File: rtl/therm_irq.sv
`timescale 1ns/1ps
module therm_irq #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] limit_i,
  input  logic          clr_i,
  input  logic          mask_i,
  output logic          pend_o,
  output logic          irq_o
);
  logic hit;

  assign hit = run_i && ((limit_i == '0) || (cnt_i > limit_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (clr_i) pend_o <= 1'b0;
    else if (hit)   pend_o <= 1'b1;
  end

  assign irq_o = pend_o & mask_i;
endmodule

// File: rtl/therm_timer.sv
`timescale 1ns/1ps
module therm_timer
  import therm_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FLAG_UNITS  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          therm_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          boost_o
);
  cfg_t          cfg;
  logic [DW-1:0] limit;
  logic          mask;
  logic          sync_n;
  logic          ast;
  logic [DW-1:0] cnt;
  logic [DW-1:0] status;
  logic          pend;
  logic          clr_status;
  logic          clr_irq;

  therm_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .async_ni(therm_ni), .sync_no(sync_n)
  );

  therm_regs #(.DW(DW)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .cfg_o(cfg), .limit_o(limit), .mask_o(mask)
  );

  assign ast        = cfg.en & ~sync_n;
  assign clr_status = rd_en_i && (addr_i == ADDR_STATUS);
  assign clr_irq    = rd_en_i && (addr_i == ADDR_IRQ);

  therm_count #(.CW(DW), .FLAG_UNITS(FLAG_UNITS)) i_count (
    .clk_i, .rst_ni, .run_i(ast), .tick_i, .clr_i(clr_status),
    .cnt_o(cnt), .status_o(status)
  );

  therm_irq #(.CW(DW)) i_irq (
    .clk_i, .rst_ni, .run_i(ast), .cnt_i(cnt), .limit_i(limit),
    .clr_i(clr_irq), .mask_i(mask), .pend_o(pend), .irq_o
  );

  assign boost_o = ast & cfg.boost;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CFG: begin
        rdata_o[CFG_LOCK_BIT]  = cfg.lock;
        rdata_o[CFG_BOOST_BIT] = cfg.boost;
        rdata_o[CFG_EN_BIT]    = cfg.en;
      end
      ADDR_LIMIT:  rdata_o = limit;
      ADDR_STATUS: rdata_o = status;
      ADDR_IRQ: begin
        rdata_o[0]            = pend;
        rdata_o[IRQ_MASK_BIT] = mask;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/therm_timer_chk.sv
`timescale 1ns/1ps
module therm_timer_chk
  import therm_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_en_i,
  input logic [1:0]    addr_i,
  input logic [DW-1:0] status,
  input cfg_t          cfg,
  input logic [DW-1:0] limit,
  input logic          pend,
  input logic          ast
);
  logic rd_st, rd_irq;
  assign rd_st  = rd_en_i && (addr_i == ADDR_STATUS);
  assign rd_irq = rd_en_i && (addr_i == ADDR_IRQ);

  AST_STATUS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st |=> (status == '0)); // R4

  AST_COUNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status == {DW{1'b1}}) && !rd_st |=> (status == {DW{1'b1}})); // R5

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend && !rd_irq |=> pend); // R6

  AST_LIMIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ast && (limit == '0) && !rd_irq |=> pend); // R7

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.en && !rd_st |=> $stable(status)); // R10

  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.lock |=> $stable(cfg)); // R11
endmodule

bind therm_timer therm_timer_chk #(.DW(DW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .addr_i(addr_i),
  .status(status), .cfg(cfg), .limit(limit), .pend(pend), .ast(ast)
);

// File: tb/test_therm_timer.sv
`timescale 1ns/1ps
module test_therm_timer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       therm_ni = 1'b1;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_o, boost_o;

  therm_timer i_therm_timer (
    .clk_i(clk), .rst_ni, .tick_i, .therm_ni, .wr_en_i, .rd_en_i,
    .addr_i, .wdata_i, .rdata_o, .irq_o, .boost_o
  );

  always #5 clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string req   = "R1";

  // tick generator
  int tick_per = 0;
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt++;
    tick_i = (tick_per > 0) && ((tcnt % tick_per) == 0);
  end

  // reference model
  bit m_en, m_boost, m_lock, m_mask, m_flag, m_pend;
  int m_limit, m_cnt;
  bit d1, d2;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_boost = 0; m_lock = 0; m_mask = 0; m_flag = 0; m_pend = 0;
      m_limit = 0; m_cnt = 0; d1 = 1; d2 = 1;
    end else begin
      bit a;
      bit n_en, n_boost, n_lock, n_mask, n_flag, n_pend;
      int n_limit, n_cnt;
      a = m_en && !d2;
      n_en = m_en; n_boost = m_boost; n_lock = m_lock; n_mask = m_mask;
      n_flag = m_flag; n_pend = m_pend; n_limit = m_limit; n_cnt = m_cnt;
      if (wr_en_i && addr_i == 2'd0 && !m_lock) begin
        n_en = wdata_i[0]; n_boost = wdata_i[1]; n_lock = wdata_i[7];
      end
      if (wr_en_i && addr_i == 2'd1) n_limit = int'(wdata_i);
      if (wr_en_i && addr_i == 2'd3) n_mask = wdata_i[1];
      if (rd_en_i && addr_i == 2'd2) begin
        n_cnt = 0; n_flag = 0;
      end else if (a) begin
        n_flag = 1;
        if (tick_i && m_cnt < 255) n_cnt = m_cnt + 1;
      end
      if (rd_en_i && addr_i == 2'd3) n_pend = 0;
      else if (a && (m_limit == 0 || m_cnt > m_limit)) n_pend = 1;
      d2 = d1; d1 = therm_ni;
      m_en = n_en; m_boost = n_boost; m_lock = n_lock; m_mask = n_mask;
      m_flag = n_flag; m_pend = n_pend; m_limit = n_limit; m_cnt = n_cnt;
    end
  end

  function automatic logic [7:0] exp_rdata(logic [1:0] a);
    case (a)
      2'd0: return {m_lock, 5'b0, m_boost, m_en};
      2'd1: return 8'(m_limit);
      2'd2: return (m_cnt >= 2) ? 8'(m_cnt) : {7'b0, m_flag};
      default: return {6'b0, m_mask, m_pend};
    endcase
  endfunction

  // compare every clock, away from both edges
  always @(negedge clk) begin
    #2;
    if (!done) begin
      logic [7:0] er;
      logic ei, eb;
      er = exp_rdata(addr_i);
      ei = m_pend && m_mask;
      eb = m_en && m_boost && !d2;
      n_vec++;
      if (rdata_o !== er || irq_o !== ei || boost_o !== eb) begin
        n_bad++;
        $display("FAIL %s addr=%0d rdata=%h/%h irq=%b/%b boost=%b/%b (actual/expected)",
                 req, addr_i, rdata_o, er, irq_o, ei, boost_o, eb);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); rd_en_i = 1; addr_i = a;
    @(negedge clk); rd_en_i = 0;
  endtask

  task automatic look(input logic [1:0] a, input int n);
    @(negedge clk); addr_i = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic therm(input logic v);
    @(negedge clk); therm_ni = v;
  endtask

  initial begin
    req = "R1";
    repeat (3) @(negedge clk);
    rst_ni = 1;
    for (int a = 0; a < 4; a++) look(2'(a), 2);

    req = "R2";
    wr(2'd0, 8'h01);
    tick_per = 4;
    look(2'd2, 1);
    therm(0); look(2'd2, 3);
    req = "R3";
    look(2'd2, 12);
    therm(1); look(2'd2, 6);
    req = "R2";
    therm(0); look(2'd2, 14);
    therm(1); look(2'd2, 4);

    req = "R4";
    rd(2'd2); look(2'd2, 3);
    therm(0); look(2'd2, 6);
    rd(2'd2); look(2'd2, 3);
    tick_per = 1;
    rd(2'd2); look(2'd2, 3);
    therm(1); rd(2'd2); look(2'd2, 3);

    req = "R5";
    tick_per = 1;
    therm(0); look(2'd2, 280);
    therm(1); look(2'd2, 4);
    rd(2'd2); look(2'd2, 3);

    req = "R6";
    tick_per = 3;
    wr(2'd3, 8'h02);
    wr(2'd1, 8'h03);
    look(2'd3, 2);
    therm(0); look(2'd3, 20);
    therm(1); look(2'd3, 4);
    rd(2'd3); look(2'd3, 3);
    req = "R8";
    wr(2'd3, 8'h00);
    rd(2'd2);
    therm(0); look(2'd3, 20);
    wr(2'd3, 8'h02); look(2'd3, 3);
    therm(1); rd(2'd3); look(2'd3, 3);

    req = "R7";
    tick_per = 0;
    rd(2'd2);
    wr(2'd1, 8'h00);
    therm(0); look(2'd3, 5);
    therm(1); rd(2'd3); look(2'd3, 3);

    req = "R9";
    tick_per = 2;
    wr(2'd0, 8'h03);
    therm(0); look(2'd0, 6);
    therm(1); look(2'd0, 4);

    req = "R10";
    rd(2'd2); rd(2'd3);
    wr(2'd0, 8'h02);
    therm(0); look(2'd2, 10);
    look(2'd3, 4);
    therm(1); look(2'd2, 3);

    req = "R11";
    wr(2'd0, 8'h83); look(2'd0, 2);
    wr(2'd0, 8'h00); look(2'd0, 2);
    therm(0); look(2'd0, 4);
    therm(1); look(2'd0, 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog %s expired", req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule